// File: doc/BRIEF.md
# I2C Master Bit-Level Engine

This block turns single bus operations into the exact line activity of an open-drain two-wire serial bus. A host issues one command at a time over a valid/ready handshake: bus recovery, START, STOP, write one byte, or read one byte with a chosen acknowledge level. The engine plays the command out against a quarter-bit time base and then raises a one-cycle completion pulse. With that pulse it returns the acknowledge bit sampled after a write, or the byte received by a read.

Both bus lines leave the block as pull-down enables. A line the engine is not pulling is released and reads high through the external pull-up, so the engine never drives a line high. The length of one quarter-bit, in clock cycles, is the parameter `DIV`. The host sequences transactions itself. Clock stretching and multi-master arbitration are not handled.

Top module: `i2c_bit_engine`

## Requirements
- R1: While the active-low asynchronous reset is asserted, both pull-down enables are 0 (lines released), `cmd_ready` is 1 and `done` is 0. This holds even when reset arrives in the middle of a command.
- R2: A command is taken in a cycle where `cmd_valid` and `cmd_ready` are both 1. For a known opcode (0 to 4), `cmd_ready` is 0 from the next cycle until the command finishes. `done` is then 1 for exactly one cycle, and `cmd_ready` is 1 in that cycle.
- R3: Each quarter lasts `DIV` clock cycles, and the lines change only at quarter boundaries. From acceptance to `done`, a command takes the following numbers of quarters × `DIV`: START 4, STOP 4, write 37, read 29, recovery 40.
- R4: START (opcode 1) runs four quarters. It first waits one quarter with the lines unchanged, then releases SDA, then releases SCL, then pulls SDA low. SDA stays pulled at the end.
- R5: STOP (opcode 2) runs four quarters. It pulls SCL low, then pulls SDA low, then releases SCL, then releases SDA.
- R6: Write (opcode 3) sends `cmd_wdata` MSB first, 4 quarters per bit. In each bit, SCL is low for one quarter, SDA is then set with SCL still low, and SCL is released for two quarters. SDA never changes while SCL is released except inside START, STOP or recovery.
- R7: After the 8th written bit, SDA is released and SCL gets one two-quarter high pulse, followed by one low quarter. `rsp_ack` takes the SDA level seen at the end of that high pulse: 1 means NACK, 0 means ACK.
- R8: Read (opcode 4) releases SDA and takes 8 bits MSB first, 3 quarters per bit: SCL low one quarter, SCL high two quarters. SDA is sampled at the end of the first high quarter, and the byte appears on `rsp_data`.
- R9: After the 8 read bits, the engine drives the acknowledge bit with the same five-quarter shape as R7. `cmd_ack_lvl`=0 pulls SDA low (ACK); `cmd_ack_lvl`=1 leaves SDA released (NACK).
- R10: Recovery (opcode 0) keeps SDA released and gives 9 SCL pulses, each two quarters low and two quarters high, then a full STOP. It ends with both lines released.
- R11: Opcodes 5 to 7 are accepted and answered with `done` in the next cycle. They cause no line activity and do not lower `cmd_ready`.
- R12: After a write, SCL is left pulled low and SDA released. After a read, SCL is left low and SDA holds the acknowledge level. After STOP and recovery, both lines are released. After START, SCL is released and SDA is pulled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command can be taken |
| cmd_op | input | 3 | Opcode: 0 recovery, 1 START, 2 STOP, 3 write, 4 read |
| cmd_wdata | input | DATA_W | Byte to write |
| cmd_ack_lvl | input | 1 | Acknowledge level after a read (0 ACK, 1 NACK) |
| done | output | 1 | One-cycle completion pulse |
| rsp_data | output | DATA_W | Byte received by the last read |
| rsp_ack | output | 1 | Acknowledge sampled after the last write (1 = NACK) |
| sda_in | input | 1 | Level seen on the SDA wire |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
Four properties are checked on every cycle: the single-cycle completion pulse and the ready handshake, a minimum spacing of `DIV` cycles between SCL transitions, and SDA holding still while SCL is released outside START, STOP and recovery. Only the bench scenarios can show the rest: the full length of each command, the number of SCL pulses, MSB-first ordering of written and read bytes, acknowledge sampling and driving, and the line levels each command leaves behind. A responder in the bench supplies those bytes and acknowledges and records what the bus carries.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

   typedef enum logic [2:0] {
      OP_RECOVER = 3'd0,
      OP_START   = 3'd1,
      OP_STOP    = 3'd2,
      OP_WRITE   = 3'd3,
      OP_READ    = 3'd4
   } op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RECOVER,
      ST_START,
      ST_STOP,
      ST_WBIT,
      ST_WACK,
      ST_RBIT,
      ST_RACK
   } st_e;

   // pull-down enables for the two bus lines: 1 = pulled low
   typedef struct packed {
      logic scl_pull;
      logic sda_pull;
   } lines_t;

endpackage

// File: rtl/i2cb_qtick.sv
module i2cb_qtick #(
   parameter int DIV = 250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt;

   // held at zero while idle so the first quarter is a full DIV cycles
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || cnt == LAST)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == LAST);
endmodule

// File: rtl/i2cb_drive.sv
module i2cb_drive
   import i2cb_pkg::*;
(
   input  st_e        st,
   input  logic [2:0] q,
   input  logic       bit_val,
   input  logic       ack_pull,
   input  lines_t     cur,
   output lines_t     nxt
);
   // line levels for the quarter (st, q) about to begin
   always_comb begin
      nxt = cur;
      unique case (st)
         ST_IDLE: nxt = cur;
         ST_RECOVER: begin
            nxt.sda_pull = 1'b0;
            nxt.scl_pull = (q < 3'd2);
         end
         ST_START: begin
            case (q)
               3'd0:    nxt = cur;
               3'd1:    nxt = '{scl_pull: cur.scl_pull, sda_pull: 1'b0};
               3'd2:    nxt = '{scl_pull: 1'b0, sda_pull: 1'b0};
               default: nxt = '{scl_pull: 1'b0, sda_pull: 1'b1};
            endcase
         end
         ST_STOP: begin
            case (q)
               3'd0:    nxt = '{scl_pull: 1'b1, sda_pull: cur.sda_pull};
               3'd1:    nxt = '{scl_pull: 1'b1, sda_pull: 1'b1};
               3'd2:    nxt = '{scl_pull: 1'b0, sda_pull: 1'b1};
               default: nxt = '{scl_pull: 1'b0, sda_pull: 1'b0};
            endcase
         end
         ST_WBIT: begin
            if (q == 3'd0)
               nxt = '{scl_pull: 1'b1, sda_pull: cur.sda_pull};
            else
               nxt = '{scl_pull: (q == 3'd1), sda_pull: ~bit_val};
         end
         ST_WACK: begin
            if (q == 3'd0)
               nxt = '{scl_pull: 1'b1, sda_pull: cur.sda_pull};
            else
               nxt = '{scl_pull: (q == 3'd1 || q == 3'd4), sda_pull: 1'b0};
         end
         ST_RBIT: begin
            nxt = '{scl_pull: (q == 3'd0), sda_pull: 1'b0};
         end
         ST_RACK: begin
            if (q == 3'd0)
               nxt = '{scl_pull: 1'b1, sda_pull: 1'b0};
            else
               nxt = '{scl_pull: (q == 3'd1 || q == 3'd4), sda_pull: ack_pull};
         end
         default: nxt = cur;
      endcase
   end
endmodule

// File: rtl/i2cb_seq.sv
module i2cb_seq
   import i2cb_pkg::*;
#(
   parameter int DATA_W         = 8,
   parameter int RECOVER_PULSES = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic              cmd_ack_lvl,
   input  logic              sda_in,
   output logic              cmd_ready,
   output logic              busy,
   output logic              step,
   output st_e               st_n,
   output logic [2:0]        q_n,
   output logic              bit_n,
   output logic              ackdrv_n,
   output logic              done,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_ack
);
   localparam int MAXC = (DATA_W > RECOVER_PULSES) ? DATA_W : RECOVER_PULSES;
   localparam int BCW  = $clog2(MAXC + 1);
   localparam logic [BCW-1:0] LAST_BIT   = BCW'(DATA_W - 1);
   localparam logic [BCW-1:0] LAST_PULSE = BCW'(RECOVER_PULSES - 1);

   st_e               st;
   logic [2:0]        q;
   logic [BCW-1:0]    bc, bc_n;
   logic [DATA_W-1:0] sh, sh_n, rd;
   logic              ackl, ackl_n;
   logic              fin, accept;

   assign cmd_ready = (st == ST_IDLE);
   assign busy      = ~cmd_ready;
   assign accept    = cmd_valid && cmd_ready;
   assign step      = accept || tick;
   assign bit_n     = sh_n[DATA_W-1];
   assign ackdrv_n  = ~ackl_n;
   assign rsp_data  = rd;

   always_comb begin
      st_n   = st;
      q_n    = q;
      bc_n   = bc;
      sh_n   = sh;
      ackl_n = ackl;
      fin    = 1'b0;
      if (accept) begin
         q_n    = 3'd0;
         bc_n   = '0;
         sh_n   = cmd_wdata;
         ackl_n = cmd_ack_lvl;
         case (cmd_op)
            OP_RECOVER: st_n = ST_RECOVER;
            OP_START:   st_n = ST_START;
            OP_STOP:    st_n = ST_STOP;
            OP_WRITE:   st_n = ST_WBIT;
            OP_READ:    st_n = ST_RBIT;
            default:    fin  = 1'b1;
         endcase
      end else if (tick) begin
         q_n = q + 3'd1;
         case (st)
            ST_RECOVER: if (q == 3'd3) begin
               q_n = 3'd0;
               if (bc == LAST_PULSE) begin
                  st_n = ST_STOP;
                  bc_n = '0;
               end else
                  bc_n = bc + 1'b1;
            end
            ST_START, ST_STOP: if (q == 3'd3) begin
               st_n = ST_IDLE;
               fin  = 1'b1;
            end
            ST_WBIT: if (q == 3'd3) begin
               q_n  = 3'd0;
               sh_n = {sh[DATA_W-2:0], 1'b0};
               if (bc == LAST_BIT) begin
                  st_n = ST_WACK;
                  bc_n = '0;
               end else
                  bc_n = bc + 1'b1;
            end
            ST_RBIT: if (q == 3'd2) begin
               q_n = 3'd0;
               if (bc == LAST_BIT) begin
                  st_n = ST_RACK;
                  bc_n = '0;
               end else
                  bc_n = bc + 1'b1;
            end
            ST_WACK, ST_RACK: if (q == 3'd4) begin
               st_n = ST_IDLE;
               fin  = 1'b1;
            end
            default: q_n = q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         q       <= 3'd0;
         bc      <= '0;
         sh      <= '0;
         ackl    <= 1'b0;
         done    <= 1'b0;
         rd      <= '0;
         rsp_ack <= 1'b0;
      end else begin
         st   <= st_n;
         q    <= q_n;
         bc   <= bc_n;
         sh   <= sh_n;
         ackl <= ackl_n;
         done <= fin;
         if (tick && st == ST_WACK && q == 3'd3)
            rsp_ack <= sda_in;
         if (tick && st == ST_RBIT && q == 3'd1)
            rd <= {rd[DATA_W-2:0], sda_in};
      end
   end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
   import i2cb_pkg::*;
#(
   parameter int DIV            = 250,
   parameter int DATA_W         = 8,
   parameter int RECOVER_PULSES = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [2:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic              cmd_ack_lvl,
   output logic              done,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_ack,
   input  logic              sda_in,
   output logic              scl_oe,
   output logic              sda_oe
);
   generate
      if (DIV < 1) begin : g_bad_div
         $error("DIV must be at least 1");
      end
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (RECOVER_PULSES < 1) begin : g_bad_pulses
         $error("RECOVER_PULSES must be at least 1");
      end
   endgenerate

   logic       tick, busy, step, bit_n, ackdrv_n;
   st_e        st_n;
   logic [2:0] q_n;
   lines_t     cur, nxt;

   i2cb_qtick #(.DIV(DIV)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .tick (tick)
   );

   i2cb_seq #(.DATA_W(DATA_W), .RECOVER_PULSES(RECOVER_PULSES)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .cmd_valid  (cmd_valid),
      .cmd_op     (cmd_op),
      .cmd_wdata  (cmd_wdata),
      .cmd_ack_lvl(cmd_ack_lvl),
      .sda_in     (sda_in),
      .cmd_ready  (cmd_ready),
      .busy       (busy),
      .step       (step),
      .st_n       (st_n),
      .q_n        (q_n),
      .bit_n      (bit_n),
      .ackdrv_n   (ackdrv_n),
      .done       (done),
      .rsp_data   (rsp_data),
      .rsp_ack    (rsp_ack)
   );

   i2cb_drive u_drv (
      .st      (st_n),
      .q       (q_n),
      .bit_val (bit_n),
      .ack_pull(ackdrv_n),
      .cur     (cur),
      .nxt     (nxt)
   );

   // line levels registered at each quarter boundary
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cur <= '0;
      else if (step)
         cur <= nxt;
   end

   assign scl_oe = cur.scl_pull;
   assign sda_oe = cur.sda_pull;
endmodule

// File: rtl/i2cb_chk.sv
module i2cb_chk #(
   parameter int DIV = 4
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic       cmd_ready,
   input logic [2:0] cmd_op,
   input logic       done,
   input logic       scl_oe,
   input logic       sda_oe
);
   localparam int GW = $clog2(DIV + 1) + 1;

   logic [2:0]    last_op;
   logic          prev_scl;
   logic [GW-1:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_op  <= 3'd2;
         prev_scl <= 1'b0;
         gap      <= GW'(DIV);
      end else begin
         prev_scl <= scl_oe;
         if (cmd_valid && cmd_ready)
            last_op <= cmd_op;
         if (scl_oe != prev_scl)
            gap <= GW'(1);
         else if (gap < GW'(DIV))
            gap <= gap + 1'b1;
      end
   end

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cmd_ready);

   p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready && cmd_op <= 3'd4) |=> !cmd_ready);

   p_scl_min_quarter_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_oe != prev_scl) |-> (gap >= GW'(DIV)));

   p_sda_still_scl_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(sda_oe) && !scl_oe && !$past(scl_oe))
         |-> (last_op == 3'd0 || last_op == 3'd1 || last_op == 3'd2));
endmodule

bind i2c_bit_engine i2cb_chk #(.DIV(DIV)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd_valid(cmd_valid),
   .cmd_ready(cmd_ready),
   .cmd_op   (cmd_op),
   .done     (done),
   .scl_oe   (scl_oe),
   .sda_oe   (sda_oe)
);

// File: tb/sim_i2c_bit_engine.sv
module sim_i2c_bit_engine;
   localparam int CLK_PERIOD = 10;
   localparam int DIV_TB     = 4;
   localparam int NVEC       = 13;

   typedef struct packed {
      logic [2:0] op;
      logic [7:0] data;
      logic       flag;      // write: responder NACKs; read: ack level
      logic [7:0] quarters;
      logic [3:0] rises;
      logic       scl_end;
      logic       sda_end;
   } vec_t;

   localparam vec_t VECS [NVEC] = '{
      '{3'd0, 8'h00, 1'b0, 8'd40, 4'd10, 1'b0, 1'b0},
      '{3'd1, 8'h00, 1'b0, 8'd4,  4'd0,  1'b0, 1'b1},
      '{3'd3, 8'hA5, 1'b0, 8'd37, 4'd9,  1'b1, 1'b0},
      '{3'd3, 8'h3C, 1'b1, 8'd37, 4'd9,  1'b1, 1'b0},
      '{3'd1, 8'h00, 1'b0, 8'd4,  4'd1,  1'b0, 1'b1},
      '{3'd3, 8'h81, 1'b0, 8'd37, 4'd9,  1'b1, 1'b0},
      '{3'd4, 8'h96, 1'b0, 8'd29, 4'd9,  1'b1, 1'b1},
      '{3'd4, 8'h5A, 1'b1, 8'd29, 4'd9,  1'b1, 1'b0},
      '{3'd2, 8'h00, 1'b0, 8'd4,  4'd1,  1'b0, 1'b0},
      '{3'd6, 8'h00, 1'b0, 8'd0,  4'd0,  1'b0, 1'b0},
      '{3'd3, 8'hFF, 1'b0, 8'd37, 4'd9,  1'b1, 1'b0},
      '{3'd4, 8'h00, 1'b1, 8'd29, 4'd9,  1'b1, 1'b0},
      '{3'd2, 8'h00, 1'b0, 8'd4,  4'd1,  1'b0, 1'b0}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic [7:0] cmd_wdata = 8'h00;
   logic       cmd_ack_lvl = 1'b0;
   logic       cmd_ready, done, rsp_ack, scl_oe, sda_oe, sda_in;
   logic [7:0] rsp_data;

   logic       wr_pull = 1'b0;
   logic       rd_act = 1'b0;
   logic [7:0] rd_byte = 8'h00;
   logic       slv_pull;
   logic [8:0] cap = 9'd0;
   int         falls = 0;
   int         rises = 0;
   int         f0 = 0;
   int         r0 = 0;
   int         checks = 0;
   int         errors = 0;
   bit         finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_bit_engine #(.DIV(DIV_TB), .DATA_W(8), .RECOVER_PULSES(9)) u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_ready  (cmd_ready),
      .cmd_op     (cmd_op),
      .cmd_wdata  (cmd_wdata),
      .cmd_ack_lvl(cmd_ack_lvl),
      .done       (done),
      .rsp_data   (rsp_data),
      .rsp_ack    (rsp_ack),
      .sda_in     (sda_in),
      .scl_oe     (scl_oe),
      .sda_oe     (sda_oe)
   );

   // bus observer: SCL falling / rising edges and SDA level at each rise
   always @(posedge scl_oe) falls++;
   always @(negedge scl_oe) begin
      rises++;
      cap = {cap[7:0], ~sda_oe};
   end

   // responder: presents read data MSB first, one bit per SCL low phase
   always_comb begin
      int k;
      k = falls - f0;
      slv_pull = wr_pull | (rd_act && k >= 0 && k < 8 && !rd_byte[3'(7 - k)]);
   end
   assign sda_in = ~(sda_oe | slv_pull);

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic run_cmd(input logic [2:0] op, input logic [7:0] d, input logic fl,
                          output int cyc);
      @(negedge clk);
      cmd_valid   = 1'b1;
      cmd_op      = op;
      cmd_wdata   = d;
      cmd_ack_lvl = fl;
      rd_byte     = d;
      wr_pull     = (op == 3'd3) && !fl;
      r0          = rises;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      f0        = falls;
      rd_act    = (op == 3'd4);
      cyc = 0;
      while (!done && cyc < 4000) begin
         @(negedge clk);
         cyc++;
      end
      rd_act  = 1'b0;
      wr_pull = 1'b0;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      int cyc;
      string tag;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 scl_oe in reset", scl_oe, 0);
      chk("R1 sda_oe in reset", sda_oe, 0);
      chk("R1 ready in reset", cmd_ready, 1);
      chk("R1 done in reset", done, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NVEC; i++) begin
         case (VECS[i].op)
            3'd0:    tag = "R10";
            3'd1:    tag = "R4";
            3'd2:    tag = "R5";
            3'd3:    tag = "R6";
            3'd4:    tag = "R8";
            default: tag = "R11";
         endcase
         run_cmd(VECS[i].op, VECS[i].data, VECS[i].flag, cyc);
         chk({tag, " R3 duration"}, cyc, VECS[i].quarters * DIV_TB);
         chk({tag, " R2 done"}, done, 1);
         chk({tag, " R2 ready at done"}, cmd_ready, 1);
         chk({tag, " SCL pulses"}, rises - r0, VECS[i].rises);
         chk({tag, " R12 scl end"}, scl_oe, VECS[i].scl_end);
         chk({tag, " R12 sda end"}, sda_oe, VECS[i].sda_end);
         if (VECS[i].op == 3'd3) begin
            chk("R6 written bits MSB first", cap[8:1], VECS[i].data);
            chk("R7 sda released in ack slot", cap[0], 1);
            chk("R7 sampled ack", rsp_ack, VECS[i].flag);
         end
         if (VECS[i].op == 3'd4) begin
            chk("R8 read byte", rsp_data, VECS[i].data);
            chk("R9 ack driven", cap[0], VECS[i].flag);
         end
         @(negedge clk);
         chk({tag, " R2 done single cycle"}, done, 0);
      end

      // R3 / R6: quarter boundaries of a write from released lines
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = 3'd3;
      cmd_wdata = 8'h00;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R2 ready low while busy", cmd_ready, 0);
      chk("R3 scl pulled in first quarter", scl_oe, 1);
      for (int n = 1; n <= 2 * DIV_TB; n++) begin
         @(negedge clk);
         if (n == DIV_TB - 1) chk("R6 sda before second quarter", sda_oe, 0);
         if (n == DIV_TB)     chk("R6 sda set in second quarter", sda_oe, 1);
         if (n == 2 * DIV_TB - 1) chk("R3 scl low till quarter 2", scl_oe, 1);
         if (n == 2 * DIV_TB)     chk("R3 scl released at quarter 2", scl_oe, 0);
      end
      while (!done) @(negedge clk);
      chk("R7 no responder gives NACK", rsp_ack, 1);

      // R1: reset in the middle of a read
      @(negedge clk);
      cmd_valid = 1'b1;
      cmd_op    = 3'd4;
      @(posedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      repeat (10) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 scl released by reset", scl_oe, 0);
      chk("R1 sda released by reset", sda_oe, 0);
      chk("R1 ready after reset", cmd_ready, 1);
      chk("R1 done after reset", done, 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      run_cmd(3'd2, 8'h00, 1'b0, cyc);
      chk("R5 stop after reset duration", cyc, 4 * DIV_TB);
      chk("R5 stop after reset lines", {scl_oe, sda_oe}, 2'b00);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule